// File: doc/BRIEF.md
# Virtual Address Pre-Translation Screen

This block sits in front of the address translation path of a 64-bit load/store and fetch pipeline. Each access presents a virtual address together with its kind, an atomic qualifier, its byte length and the current privilege state. In the same cycle, with no register on the path, the block gives one of three verdicts:

- the address is outside the canonical range (an access fault),
- a data access is not aligned to its own length (a misaligned fault),
- the access may proceed.

When the access may proceed, the block also says whether the page walker must translate it.

On a fault, the block gives the exception code, which trap-value register receives the address, and the address itself as the trap value. Everything is combinational. There is no data handshake: the caller holds the inputs for as long as it needs the answer. For that reason the block has no valid/ready pair and no back-pressure rules. Encodings used throughout:

- Access kind: 0 fetch, 1 load, 2 store, 3 treated as store.
- Verdict: 0 pass, 1 misaligned, 2 access fault.
- Trap-value target: 0 none, 1 machine register, 2 supervisor register.
- Privilege: 0 user, 1 supervisor, 3 machine.

Top module: `vaddr_screen`

## Requirements
- R1: An address whose bits 63 down to 39 are all zero or all one is canonical and is not faulted on that ground; any other pattern in those bits gives verdict 2.
- R2: A non-canonical fetch gives fault code 1 with trap-value target 2 (supervisor), whatever the privilege.
- R3: A non-canonical load gives code 5, or code 7 when the atomic qualifier is set; a non-canonical store gives code 7. For both, the target is 1 when the current privilege is 3, and 2 otherwise.
- R4: A canonical load or store whose address ANDed with (length-1) is nonzero gives verdict 1. Fetches never receive verdict 1.
- R5: A misaligned store, or a misaligned load carrying the atomic qualifier, gives code 6. Any other misaligned load gives code 4. The target is always 1.
- R6: When an address is both non-canonical and misaligned, verdict 2 wins.
- R7: The effective privilege is the saved previous privilege when the modify-privilege flag is set and the access is not a fetch; otherwise it is the current privilege.
- R8: The translate flag is 1 only when the verdict is 0, the effective privilege is below 3, and the translation-mode field equals 8.
- R9: A translation-mode value other than 0 or 8 sets the mode-illegal flag; the translate flag then stays 0.
- R10: On verdict 0, the fault code is 0, the target is 0 and the trap value is 0. On any fault, the trap value equals the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr | input | 64 | Virtual address of the access |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 store |
| acc_atomic | input | 1 | Access is part of an atomic read-modify-write |
| acc_len | input | 4 | Access length in bytes (1, 2, 4 or 8) |
| cur_priv | input | 2 | Current privilege level |
| mod_priv_en | input | 1 | Use the saved privilege for data accesses |
| saved_priv | input | 2 | Saved previous privilege |
| xlate_mode | input | 4 | Translation-mode field of the address-translation register |
| verdict | output | 2 | 0 pass, 1 misaligned, 2 access fault |
| need_xlate | output | 1 | Passed access must be translated |
| fault_code | output | 4 | Exception code, 0 on pass |
| tval_target | output | 2 | 0 none, 1 machine, 2 supervisor trap-value register |
| tval_data | output | 64 | Value for the selected trap-value register |
| mode_illegal | output | 1 | Translation-mode field holds an unsupported value |

## Verification
Every output is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The driver applies a new access just after a rising clock edge and pushes the expected outputs into a queue. The monitor pops that entry at the following falling edge, half a period later, when the combinational paths have settled. Only one access is in flight per cycle, so each popped entry is compared against the access it was pushed for.

// File: rtl/vaddr_screen_pkg.sv
package vaddr_screen_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    VERDICT_PASS     = 2'd0,
    VERDICT_MISALIGN = 2'd1,
    VERDICT_ACCESS   = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    TVAL_NONE    = 2'd0,
    TVAL_MACHINE = 2'd1,
    TVAL_SUPER   = 2'd2
  } tval_e;

  localparam logic [1:0] PRIV_MACHINE = 2'd3;

  localparam logic [3:0] CODE_NONE      = 4'd0;
  localparam logic [3:0] CODE_FETCH_ACC = 4'd1;
  localparam logic [3:0] CODE_LOAD_MIS  = 4'd4;
  localparam logic [3:0] CODE_LOAD_ACC  = 4'd5;
  localparam logic [3:0] CODE_STORE_MIS = 4'd6;
  localparam logic [3:0] CODE_STORE_ACC = 4'd7;

endpackage

// File: rtl/canon_chk.sv
module canon_chk #(
  parameter int ADDR_W  = 64,
  parameter int VA_BITS = 39,
  localparam int HI_W   = ADDR_W - VA_BITS
) (
  input  logic [HI_W-1:0] upper_bits,
  output logic            canon_ok
);
  logic all_ones;
  logic all_zero;

  assign all_ones = &upper_bits;
  assign all_zero = ~(|upper_bits);
  assign canon_ok = all_ones | all_zero;
endmodule

// File: rtl/align_chk.sv
module align_chk #(
  parameter int LEN_W = 4
) (
  input  logic [LEN_W-1:0] addr_lo,
  input  logic [LEN_W-1:0] len,
  output logic             misaligned
);
  logic [LEN_W-1:0] low_mask;

  assign low_mask   = len - LEN_W'(1);
  assign misaligned = |(addr_lo & low_mask);
endmodule

// File: rtl/priv_resolve.sv
module priv_resolve #(
  parameter int          MODE_W     = 4,
  parameter int unsigned XLATE_CODE = 8,
  parameter int unsigned BARE_CODE  = 0
) (
  input  logic              is_fetch,
  input  logic [1:0]        cur_priv,
  input  logic              mod_priv_en,
  input  logic [1:0]        saved_priv,
  input  logic [MODE_W-1:0] mode_field,
  output logic [1:0]        eff_priv,
  output logic              xlate_on,
  output logic              mode_bad
);
  import vaddr_screen_pkg::*;

  localparam logic [MODE_W-1:0] XLATE_V = MODE_W'(XLATE_CODE);
  localparam logic [MODE_W-1:0] BARE_V  = MODE_W'(BARE_CODE);

  assign eff_priv = (mod_priv_en && !is_fetch) ? saved_priv : cur_priv;
  assign xlate_on = (eff_priv != PRIV_MACHINE) && (mode_field == XLATE_V);
  assign mode_bad = (mode_field != XLATE_V) && (mode_field != BARE_V);

  always_comb begin
    // R9
    if (mode_bad) begin
      bad_mode_no_xlate_chk: assert (!xlate_on)
        else $error("translate enabled under illegal mode");
    end
  end
endmodule

// File: rtl/vaddr_screen.sv
module vaddr_screen #(
  parameter int ADDR_W  = 64,
  parameter int VA_BITS = 39,
  parameter int LEN_W   = 4,
  parameter int MODE_W  = 4
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        acc_kind,
  input  logic              acc_atomic,
  input  logic [LEN_W-1:0]  acc_len,
  input  logic [1:0]        cur_priv,
  input  logic              mod_priv_en,
  input  logic [1:0]        saved_priv,
  input  logic [MODE_W-1:0] xlate_mode,
  output logic [1:0]        verdict,
  output logic              need_xlate,
  output logic [3:0]        fault_code,
  output logic [1:0]        tval_target,
  output logic [ADDR_W-1:0] tval_data,
  output logic              mode_illegal
);
  import vaddr_screen_pkg::*;

  localparam int HI_W = ADDR_W - VA_BITS;

  acc_kind_e kind;
  logic      is_fetch;
  logic      store_class;
  logic      canon_ok;
  logic      misaligned;
  logic      xlate_on;
  logic [1:0] eff_priv;
  verdict_e  verdict_q;
  tval_e     target_q;

  assign kind        = acc_kind_e'(acc_kind);
  assign is_fetch    = (kind == ACC_FETCH);
  assign store_class = (kind == ACC_STORE) || (kind == ACC_RSVD) || acc_atomic;

  canon_chk #(.ADDR_W(ADDR_W), .VA_BITS(VA_BITS)) canon_u (
    .upper_bits (vaddr[ADDR_W-1:ADDR_W-HI_W]),
    .canon_ok   (canon_ok)
  );

  align_chk #(.LEN_W(LEN_W)) align_u (
    .addr_lo    (vaddr[LEN_W-1:0]),
    .len        (acc_len),
    .misaligned (misaligned)
  );

  priv_resolve #(.MODE_W(MODE_W)) priv_u (
    .is_fetch    (is_fetch),
    .cur_priv    (cur_priv),
    .mod_priv_en (mod_priv_en),
    .saved_priv  (saved_priv),
    .mode_field  (xlate_mode),
    .eff_priv    (eff_priv),
    .xlate_on    (xlate_on),
    .mode_bad    (mode_illegal)
  );

  always_comb begin
    verdict_q  = VERDICT_PASS;
    target_q   = TVAL_NONE;
    fault_code = CODE_NONE;
    if (!canon_ok) begin
      verdict_q = VERDICT_ACCESS;
      if (is_fetch) begin
        fault_code = CODE_FETCH_ACC;
        target_q   = TVAL_SUPER;
      end else begin
        fault_code = store_class ? CODE_STORE_ACC : CODE_LOAD_ACC;
        target_q   = (cur_priv == PRIV_MACHINE) ? TVAL_MACHINE : TVAL_SUPER;
      end
    end else if (!is_fetch && misaligned) begin
      verdict_q  = VERDICT_MISALIGN;
      fault_code = store_class ? CODE_STORE_MIS : CODE_LOAD_MIS;
      target_q   = TVAL_MACHINE;
    end
  end

  assign verdict     = verdict_q;
  assign tval_target = target_q;
  assign need_xlate  = (verdict_q == VERDICT_PASS) && xlate_on;
  assign tval_data   = (verdict_q == VERDICT_PASS) ? '0 : vaddr;

  always_comb begin
    // R6
    if (!canon_ok) begin
      canon_wins_chk: assert (verdict == VERDICT_ACCESS)
        else $error("non-canonical address not faulted");
    end
    // R4
    if (is_fetch) begin
      fetch_no_misalign_chk: assert (verdict != VERDICT_MISALIGN)
        else $error("fetch flagged misaligned");
    end
    // R8
    if (need_xlate) begin
      xlate_only_pass_chk: assert (verdict == VERDICT_PASS && eff_priv != PRIV_MACHINE)
        else $error("translate raised on fault or machine access");
    end
    // R5
    if (verdict == VERDICT_MISALIGN) begin
      misalign_tval_chk: assert (tval_target == TVAL_MACHINE && misaligned)
        else $error("misaligned fault without machine target");
    end
    // R10
    if (verdict == VERDICT_PASS) begin
      pass_quiet_chk: assert (fault_code == CODE_NONE && tval_target == TVAL_NONE)
        else $error("pass verdict carries fault info");
    end
  end
endmodule

// File: tb/vaddr_screen_tb_top.sv
module vaddr_screen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] vaddr = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_atomic = 1'b0;
  logic [3:0]  acc_len = 4'd1;
  logic [1:0]  cur_priv = 2'd3;
  logic        mod_priv_en = 1'b0;
  logic [1:0]  saved_priv = '0;
  logic [3:0]  xlate_mode = '0;
  logic [1:0]  verdict;
  logic        need_xlate;
  logic [3:0]  fault_code;
  logic [1:0]  tval_target;
  logic [63:0] tval_data;
  logic        mode_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [9:0]  exp_q[$];
  logic [63:0] exp_tv_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  vaddr_screen dut_i (
    .vaddr(vaddr), .acc_kind(acc_kind), .acc_atomic(acc_atomic), .acc_len(acc_len),
    .cur_priv(cur_priv), .mod_priv_en(mod_priv_en), .saved_priv(saved_priv),
    .xlate_mode(xlate_mode), .verdict(verdict), .need_xlate(need_xlate),
    .fault_code(fault_code), .tval_target(tval_target), .tval_data(tval_data),
    .mode_illegal(mode_illegal)
  );

  // Reference model from the requirements: {verdict, xlate, code, target, illegal}
  function automatic logic [9:0] model(input logic [63:0] a, input logic [1:0] k,
      input logic amo, input logic [3:0] len, input logic [1:0] cp, input logic mprv,
      input logic [1:0] mpp, input logic [3:0] mode);
    logic [24:0] hi;
    logic [1:0] v, tv, ep;
    logic [3:0] c;
    logic x, bad, st;
    hi  = a[63:39];
    st  = (k >= 2'd2) || amo;
    v = 2'd0; tv = 2'd0; c = 4'd0;
    if (hi != 25'd0 && hi != {25{1'b1}}) begin
      v = 2'd2;
      if (k == 2'd0) begin c = 4'd1; tv = 2'd2; end
      else begin c = st ? 4'd7 : 4'd5; tv = (cp == 2'd3) ? 2'd1 : 2'd2; end
    end else if (k != 2'd0 && (a[3:0] % len) != 4'd0) begin
      v = 2'd1; c = st ? 4'd6 : 4'd4; tv = 2'd1;
    end
    ep  = (mprv && k != 2'd0) ? mpp : cp;
    x   = (v == 2'd0) && (ep != 2'd3) && (mode == 4'd8);
    bad = (mode != 4'd0) && (mode != 4'd8);
    return {v, x, c, tv, bad};
  endfunction

  task automatic apply(input logic [63:0] a, input logic [1:0] k, input logic amo,
      input logic [3:0] len, input logic [1:0] cp, input logic mprv,
      input logic [1:0] mpp, input logic [3:0] mode, input string tag);
    logic [9:0] e;
    @(posedge clk);
    vaddr = a; acc_kind = k; acc_atomic = amo; acc_len = len;
    cur_priv = cp; mod_priv_en = mprv; saved_priv = mpp; xlate_mode = mode;
    e = model(a, k, amo, len, cp, mprv, mpp, mode);
    exp_q.push_back(e);
    exp_tv_q.push_back(e[9:8] == 2'd0 ? 64'd0 : a);
    tag_q.push_back(tag);
  endtask

  // Monitor: results are combinational, due half a period after the drive edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [9:0]  e;
      logic [9:0]  got;
      logic [63:0] etv;
      string       t;
      e   = exp_q.pop_front();
      etv = exp_tv_q.pop_front();
      t   = tag_q.pop_front();
      got = {verdict, need_xlate, fault_code, tval_target, mode_illegal};
      checks++;
      if (got !== e || tval_data !== etv) begin
        errors++;
        $display("FAIL %s: got %b tv=%h expected %b tv=%h", t, got, tval_data, e, etv);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R10 idle machine fetch at reset values
    apply(64'h0, 2'd0, 1'b0, 4'd1, 2'd3, 1'b0, 2'd0, 4'd0, "R10 reset idle");
    apply(64'h0000_8000_0000_0000, 2'd0, 1'b0, 4'd4, 2'd1, 1'b0, 2'd0, 4'd8, "R2 fetch noncanon");
    apply(64'h0000_8000_0000_0000, 2'd0, 1'b0, 4'd4, 2'd3, 1'b0, 2'd0, 4'd0, "R2 fetch noncanon machine");
    apply(64'h1234_0000_0000_1000, 2'd1, 1'b0, 4'd8, 2'd3, 1'b0, 2'd0, 4'd0, "R3 load noncanon machine");
    apply(64'h1234_0000_0000_1000, 2'd1, 1'b1, 4'd8, 2'd0, 1'b0, 2'd0, 4'd8, "R3 atomic load noncanon");
    apply(64'hFFFF_0000_0000_0000, 2'd2, 1'b0, 4'd8, 2'd1, 1'b0, 2'd0, 4'd8, "R3 store noncanon super");
    apply(64'hFFFF_0000_0000_0000, 2'd2, 1'b0, 4'd8, 2'd3, 1'b0, 2'd0, 4'd0, "R3 store noncanon machine");
    apply(64'hFFFF_FF80_0000_0000, 2'd1, 1'b0, 4'd8, 2'd3, 1'b0, 2'd0, 4'd0, "R1 high canonical");
    apply(64'h0000_0040_0000_0000, 2'd1, 1'b0, 4'd8, 2'd0, 1'b0, 2'd0, 4'd8, "R1 bit38 canonical");
    apply(64'h0000_0000_0000_1002, 2'd1, 1'b0, 4'd4, 2'd1, 1'b0, 2'd0, 4'd8, "R5 load misaligned");
    apply(64'h0000_0000_0000_1001, 2'd2, 1'b0, 4'd2, 2'd0, 1'b0, 2'd0, 4'd8, "R5 store misaligned");
    apply(64'h0000_0000_0000_1004, 2'd1, 1'b1, 4'd8, 2'd1, 1'b0, 2'd0, 4'd8, "R5 atomic misaligned");
    apply(64'h0000_0000_0000_2002, 2'd0, 1'b0, 4'd4, 2'd3, 1'b0, 2'd0, 4'd0, "R4 fetch exempt");
    apply(64'h0000_0000_0000_2003, 2'd1, 1'b0, 4'd1, 2'd3, 1'b0, 2'd0, 4'd0, "R4 byte access");
    apply(64'h0000_0000_0000_2006, 2'd2, 1'b0, 4'd2, 2'd3, 1'b0, 2'd0, 4'd0, "R4 half aligned");
    apply(64'h0F00_0000_0000_0003, 2'd1, 1'b0, 4'd8, 2'd0, 1'b0, 2'd0, 4'd8, "R6 canon over align");
    apply(64'h0000_0000_0000_3000, 2'd1, 1'b0, 4'd8, 2'd3, 1'b1, 2'd1, 4'd8, "R7 saved priv data");
    apply(64'h0000_0000_0000_3000, 2'd0, 1'b0, 4'd4, 2'd3, 1'b1, 2'd1, 4'd8, "R7 fetch ignores saved");
    apply(64'h0000_0000_0000_3000, 2'd2, 1'b0, 4'd8, 2'd0, 1'b1, 2'd3, 4'd8, "R7 saved machine");
    apply(64'h0000_0000_0000_3000, 2'd1, 1'b0, 4'd8, 2'd1, 1'b0, 2'd0, 4'd0, "R8 bare mode");
    apply(64'h0000_0000_0000_1000, 2'd2, 1'b0, 4'd8, 2'd1, 1'b0, 2'd0, 4'd8, "R8 translated store");
    apply(64'h0000_0000_0000_1000, 2'd1, 1'b0, 4'd8, 2'd0, 1'b0, 2'd0, 4'd5, "R9 illegal mode");
    apply(64'h0000_0000_0000_1000, 2'd0, 1'b0, 4'd4, 2'd1, 1'b0, 2'd0, 4'd9, "R9 illegal mode fetch");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule